// File: doc/BRIEF.md
# Drive Status and Attention Logic

This block holds a 16-bit status register for each drive attached to a disk controller (four by default). The command sequencer and the data-transfer engine raise individual status bits through a set strobe. A status-read request selects one drive. The block then returns a formatted status word with a recomputed error-summary bit, and clears that drive's transient bits.

The attention bits of all drives are gathered into a poll word. The block also produces a one-cycle command-flag request. This request fires when a status read leaves attention pending on any drive. It also fires when a drive's heads load while polling is enabled. A parameter selects between the newer and the older interface variant. The variants differ in the error-summary mask, in three bits that must read as zero, in the meaning of bit 10, and in the word an unloaded drive returns.

Top module: `drv_status_attn`

## Requirements
- R1: A set strobe (`set_valid`) ORs `set_mask` into the status register of drive `set_drv`. Bits 0 and 7 are never stored. Bit layout: 15 attention, 14 first-status, 13 overrun, 12 read/write unsafe, 11 access unsafe, 10 write-protected (newer) or hunting (older), 9 seek incomplete, 8 seek error, 6 not ready, 5 end of cylinder, 4 address error, 3 flagged, 2 busy, 1 data error, 0 any error.
- R2: Bit 0 of the returned word is 1 exactly when the word holds any bit of the variant's error mask. The newer mask is 0xFB7E. The older mask is 0x7B72, which leaves out bits 15, 3 and 2.
- R3: On the newer variant, bits 15, 12 and 9 of a loaded drive's word read 0, and bit 10 equals `wprot` of the selected drive.
- R4: A drive whose `loaded` input is 0 returns 0x0045 (not ready, busy, any error) on the newer variant and 0x0041 on the older one.
- R5: `stat_word` and `stat_valid` are registered on the edge that samples `rd_req`. The word shows the register contents from before that cycle's clear. After reset `stat_valid`, `flag_req` and `attn_vec` are 0.
- R6: A status read clears bits 15, 14, 13, 12, 11, 5, 4, 3 and 1 of the selected drive. Bits 10, 9, 8, 6 and 2 are kept.
- R7: When a set strobe and a status-read clear hit the same bit in one cycle, the bit ends up set.
- R8: Bit i of `attn_vec` is the attention bit (15) of drive i.
- R9: A status read enables polling. It pulses `flag_req` on the next edge if any drive's attention is still set after the clear and the same-cycle sets.
- R10: A rising `loaded` input, including a drive already loaded when reset releases, sets attention and first-status of that drive. It pulses `flag_req` if polling is enabled.
- R11: `ctl_clear` takes precedence over every other update. A loaded drive keeps only bit 14, an unloaded drive is zeroed, and polling is disabled. `poll_arm` enables polling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_valid | input | 1 | Status set strobe |
| set_drv | input | 2 | Drive targeted by the set strobe |
| set_mask | input | 16 | Bits to set |
| loaded | input | 4 | Heads-loaded indication per drive |
| wprot | input | 4 | Write-protect indication per drive |
| rd_req | input | 1 | Status-read request |
| rd_drv | input | 2 | Drive selected for the read |
| poll_arm | input | 1 | Enable attention polling |
| ctl_clear | input | 1 | Controller clear |
| stat_word | output | 16 | Formatted status word |
| stat_valid | output | 1 | Status word valid (one cycle) |
| attn_vec | output | 4 | Attention poll word |
| flag_req | output | 1 | Command-flag request pulse |

## Verification
Each result is due one edge after its stimulus. This holds for the status word, its valid, the flag pulse, and the poll word after a set, read, load or clear. No result waits longer. The bench drives every input on the falling edge and samples on the next falling edge, so each check lands half a cycle after the register that produced it. Both variants are instantiated side by side on the same stimulus. Every bit of every drive is swept through set-then-read, and the bench compares each word against a word it builds arithmetically from the requirements.

// File: rtl/drvstat_pkg.sv
package drvstat_pkg;
  localparam int STAT_W = 16;

  localparam logic [STAT_W-1:0] M_ATTN    = 16'h8000;
  localparam logic [STAT_W-1:0] M_FIRST   = 16'h4000;
  localparam logic [STAT_W-1:0] M_WPROT   = 16'h0400;
  localparam logic [STAT_W-1:0] M_NRDY    = 16'h0040;
  localparam logic [STAT_W-1:0] M_BUSY    = 16'h0004;
  localparam logic [STAT_W-1:0] M_ANYERR  = 16'h0001;
  localparam logic [STAT_W-1:0] M_STORE   = 16'hFF7E;
  localparam logic [STAT_W-1:0] M_RDCLR   = 16'hF83A;
  localparam logic [STAT_W-1:0] M_ZERO_NEW = 16'h9200;
  localparam logic [STAT_W-1:0] M_ERR_NEW = 16'hFB7E;
  localparam logic [STAT_W-1:0] M_ERR_OLD = 16'h7B72;

  function automatic logic [STAT_W-1:0] err_mask(input bit newer);
    return newer ? M_ERR_NEW : M_ERR_OLD;
  endfunction
endpackage

// File: rtl/drvstat_bank.sv
module drvstat_bank
  import drvstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [STAT_W-1:0] set_bits,
  input  logic              rd_clr,
  input  logic              ld_evt,
  input  logic              ctl_clear,
  input  logic              loaded,
  output logic [STAT_W-1:0] q,
  output logic [STAT_W-1:0] q_nxt
);
  logic [STAT_W-1:0] kept;
  logic [STAT_W-1:0] raised;

  always_comb begin
    kept   = rd_clr ? (q & ~M_RDCLR) : q;
    raised = (set_en ? (set_bits & M_STORE) : '0) |
             (ld_evt ? (M_ATTN | M_FIRST) : '0);
    if (ctl_clear) begin
      q_nxt = loaded ? (q & M_FIRST) : '0;
    end else begin
      q_nxt = kept | raised;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end
endmodule

// File: rtl/drvstat_fmt.sv
module drvstat_fmt
  import drvstat_pkg::*;
#(
  parameter bit NEWER = 1'b1
) (
  input  logic [STAT_W-1:0] raw,
  input  logic              loaded,
  input  logic              wprot,
  output logic [STAT_W-1:0] word
);
  localparam logic [STAT_W-1:0] ERRM = err_mask(NEWER);
  logic [STAT_W-1:0] body;

  generate
    if (NEWER) begin : g_new
      always_comb begin
        if (loaded) begin
          body = (raw & ~(M_ANYERR | M_ZERO_NEW | M_WPROT)) |
                 (wprot ? M_WPROT : '0);
        end else begin
          body = M_NRDY | M_BUSY;
        end
      end
    end else begin : g_old
      always_comb begin
        body = loaded ? (raw & ~M_ANYERR) : M_NRDY;
      end
    end
  endgenerate

  always_comb begin
    word    = body;
    word[0] = |(body & ERRM);
  end
endmodule

// File: rtl/drv_status_attn.sv
module drv_status_attn
  import drvstat_pkg::*;
#(
  parameter int NUM_DRV = 4,
  parameter bit NEWER   = 1'b1,
  localparam int DRV_W  = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_valid,
  input  logic [DRV_W-1:0]   set_drv,
  input  logic [STAT_W-1:0]  set_mask,
  input  logic [NUM_DRV-1:0] loaded,
  input  logic [NUM_DRV-1:0] wprot,
  input  logic               rd_req,
  input  logic [DRV_W-1:0]   rd_drv,
  input  logic               poll_arm,
  input  logic               ctl_clear,
  output logic [STAT_W-1:0]  stat_word,
  output logic               stat_valid,
  output logic [NUM_DRV-1:0] attn_vec,
  output logic               flag_req
);
  localparam logic [STAT_W-1:0] ERRM = err_mask(NEWER);

  logic [STAT_W-1:0]  regs    [NUM_DRV];
  logic [STAT_W-1:0]  regs_nx [NUM_DRV];
  logic [NUM_DRV-1:0] ld_q;
  logic [NUM_DRV-1:0] ld_rise;
  logic [NUM_DRV-1:0] attn_nx;
  logic               poll_q, poll_nx;
  logic               flag_nx;
  logic [STAT_W-1:0]  sel_raw;
  logic [STAT_W-1:0]  fmt_word;

  assign ld_rise = loaded & ~ld_q;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_DRV; gi++) begin : g_drv
      drvstat_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (set_valid && (set_drv == DRV_W'(gi))),
        .set_bits  (set_mask),
        .rd_clr    (rd_req && (rd_drv == DRV_W'(gi))),
        .ld_evt    (ld_rise[gi]),
        .ctl_clear (ctl_clear),
        .loaded    (loaded[gi]),
        .q         (regs[gi]),
        .q_nxt     (regs_nx[gi])
      );
      assign attn_vec[gi] = regs[gi][15];
      assign attn_nx[gi]  = regs_nx[gi][15];

      AST_LOAD_SETS_ATTN: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_rise[gi] && !ctl_clear) |=> attn_vec[gi]); // R10
    end
  endgenerate

  always_comb begin
    sel_raw = regs[0];
    for (int i = 1; i < NUM_DRV; i++) begin
      if (rd_drv == DRV_W'(i)) sel_raw = regs[i];
    end
  end

  drvstat_fmt #(.NEWER(NEWER)) u_fmt (
    .raw    (sel_raw),
    .loaded (loaded[rd_drv]),
    .wprot  (wprot[rd_drv]),
    .word   (fmt_word)
  );

  always_comb begin
    if (ctl_clear) begin
      poll_nx = 1'b0;
    end else if (rd_req || poll_arm) begin
      poll_nx = 1'b1;
    end else begin
      poll_nx = poll_q;
    end
    flag_nx = !ctl_clear &&
              ((rd_req && (|attn_nx)) || ((|ld_rise) && poll_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q       <= '0;
      poll_q     <= 1'b0;
      flag_req   <= 1'b0;
      stat_valid <= 1'b0;
      stat_word  <= '0;
    end else begin
      ld_q       <= loaded;
      poll_q     <= poll_nx;
      flag_req   <= flag_nx;
      stat_valid <= rd_req;
      if (rd_req) begin
        stat_word <= fmt_word;
      end
    end
  end

  AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> (stat_word[0] == |(stat_word & ERRM))); // R2

  AST_RD_CLEARS_ATTN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !set_valid && !(|ld_rise) && !ctl_clear) |=>
      !attn_vec[$past(rd_drv)]); // R6

  AST_CLEAR_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clear |=> !flag_req); // R11

  generate
    if (NEWER) begin : g_mbz
      AST_NEWER_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> (stat_word[15] == 1'b0 && stat_word[12] == 1'b0 &&
                        stat_word[9] == 1'b0)); // R3
    end
  endgenerate
endmodule

// File: tb/sim_drv_status_attn.sv
module sim_drv_status_attn;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        set_valid;
  logic [1:0]  set_drv;
  logic [15:0] set_mask;
  logic [3:0]  loaded;
  logic [3:0]  wprot;
  logic        rd_req;
  logic [1:0]  rd_drv;
  logic        poll_arm;
  logic        ctl_clear;
  logic [15:0] sw0, sw1;
  logic        sv0, sv1, fl0, fl1;
  logic [3:0]  av0, av1;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] m [2][4];
  bit poll_m;

  always #2 clk = ~clk;

  drv_status_attn #(.NUM_DRV(4), .NEWER(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_drv(set_drv),
    .set_mask(set_mask), .loaded(loaded), .wprot(wprot), .rd_req(rd_req),
    .rd_drv(rd_drv), .poll_arm(poll_arm), .ctl_clear(ctl_clear),
    .stat_word(sw0), .stat_valid(sv0), .attn_vec(av0), .flag_req(fl0));

  drv_status_attn #(.NUM_DRV(4), .NEWER(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_drv(set_drv),
    .set_mask(set_mask), .loaded(loaded), .wprot(wprot), .rd_req(rd_req),
    .rd_drv(rd_drv), .poll_arm(poll_arm), .ctl_clear(ctl_clear),
    .stat_word(sw1), .stat_valid(sv1), .attn_vec(av1), .flag_req(fl1));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input int v, input int d);
    logic [15:0] w;
    if (!loaded[d]) return (v == 0) ? 16'h0045 : 16'h0041;
    w = m[v][d] & 16'hFF7E;
    if (v == 0) begin
      w = w & ~16'h9600;
      if (wprot[d]) w = w | 16'h0400;
    end
    w[0] = |(w & ((v == 0) ? 16'hFB7E : 16'h7B72));
    return w;
  endfunction

  function automatic logic [3:0] exp_attn();
    logic [3:0] a;
    for (int i = 0; i < 4; i++) a[i] = m[0][i][15];
    return a;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_set(input int d, input logic [15:0] mask);
    set_valid = 1'b1; set_drv = 2'(d); set_mask = mask;
    step();
    set_valid = 1'b0;
    for (int v = 0; v < 2; v++) m[v][d] = m[v][d] | (mask & 16'hFF7E);
  endtask

  task automatic do_read(input int d, input string req);
    logic [15:0] e0, e1;
    logic ef;
    rd_req = 1'b1; rd_drv = 2'(d);
    e0 = exp_word(0, d);
    e1 = exp_word(1, d);
    for (int v = 0; v < 2; v++) m[v][d] = m[v][d] & ~16'hF83A;
    poll_m = 1'b1;
    ef = |exp_attn();
    step();
    rd_req = 1'b0;
    check({req, " newer word"}, sw0, e0);
    check({req, " older word"}, sw1, e1);
    check("R5 valid", {14'd0, sv1, sv0}, 16'h0003);
    check("R9 flag after read", {14'd0, fl1, fl0}, {14'd0, ef, ef});
    check("R8 poll word", {8'd0, av1, av0}, {8'd0, exp_attn(), exp_attn()});
  endtask

  task automatic do_load(input int d, input string req);
    logic ef;
    ef = poll_m;
    loaded[d] = 1'b1;
    for (int v = 0; v < 2; v++) m[v][d] = m[v][d] | 16'hC000;
    step();
    check({req, " attn"}, {8'd0, av1, av0}, {8'd0, exp_attn(), exp_attn()});
    check({req, " flag"}, {14'd0, fl1, fl0}, {14'd0, ef, ef});
  endtask

  task automatic do_clear();
    ctl_clear = 1'b1;
    for (int v = 0; v < 2; v++)
      for (int d = 0; d < 4; d++)
        m[v][d] = loaded[d] ? (m[v][d] & 16'h4000) : 16'h0000;
    poll_m = 1'b0;
    step();
    ctl_clear = 1'b0;
    check("R11 clear flag", {14'd0, fl1, fl0}, 16'h0000);
    check("R11 clear attn", {8'd0, av1, av0}, 16'h0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; set_valid = 1'b0; set_drv = '0; set_mask = '0;
    loaded = '0; wprot = '0; rd_req = 1'b0; rd_drv = '0;
    poll_arm = 1'b0; ctl_clear = 1'b0; poll_m = 1'b0;
    for (int v = 0; v < 2; v++) for (int d = 0; d < 4; d++) m[v][d] = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    check("R5 reset valid/flag", {12'd0, sv1, sv0, fl1, fl0}, 16'h0000);
    check("R5 reset attn", {8'd0, av1, av0}, 16'h0000);

    // R10: loads with polling still disabled
    for (int d = 0; d < 4; d++) do_load(d, "R10 load no poll");
    // R9: each read leaves others' attention pending
    for (int d = 0; d < 4; d++) do_read(d, "R1 R6 first read");

    // R1 R2 R3: single-bit sweep on every drive
    for (int d = 0; d < 4; d++) begin
      wprot = (d % 2 == 0) ? 4'b0101 : 4'b1010;
      for (int b = 0; b < 16; b++) begin
        do_set(d, 16'(1) << b);
        do_read(d, "R2 sweep");
      end
    end
    wprot = 4'b0000;

    // R6: full set, read twice, retained bits visible on second read
    do_set(1, 16'hFFFF);
    do_read(1, "R6 full");
    do_read(1, "R6 retained");

    // R7: set and clear of the same bit in one cycle
    rd_req = 1'b1; rd_drv = 2'd2; set_valid = 1'b1; set_drv = 2'd2;
    set_mask = 16'h8010;
    begin
      logic [15:0] e0, e1;
      e0 = exp_word(0, 2);
      e1 = exp_word(1, 2);
      for (int v = 0; v < 2; v++) m[v][2] = (m[v][2] & ~16'hF83A) | 16'h8010;
      poll_m = 1'b1;
      step();
      rd_req = 1'b0; set_valid = 1'b0;
      check("R7 newer word", sw0, e0);
      check("R7 older word", sw1, e1);
      check("R7 attn kept", {8'd0, av1, av0}, {8'd0, exp_attn(), exp_attn()});
      check("R7 flag", {14'd0, fl1, fl0}, 16'h0003);
    end
    do_read(2, "R7 reread");

    // R4: unloaded drive
    loaded[3] = 1'b0;
    step();
    do_read(3, "R4 unloaded");

    // R10: reload with polling enabled
    do_load(3, "R10 load polled");
    do_read(3, "R10 after load");

    // R11: controller clear
    do_set(0, 16'hA13E);
    do_set(1, 16'h0102);
    loaded[1] = 1'b0;
    step();
    do_clear();
    for (int d = 0; d < 4; d++) do_read(d, "R11 after clear");
    do_clear();
    loaded[1] = 1'b1;
    m[0][1] = m[0][1] | 16'hC000; m[1][1] = m[1][1] | 16'hC000;
    step();
    check("R11 no poll flag", {14'd0, fl1, fl0}, 16'h0000);
    poll_arm = 1'b1; poll_m = 1'b1;
    step();
    poll_arm = 1'b0;
    loaded[2] = 1'b0;
    step();
    do_load(2, "R11 armed load");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule